// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block chooses which pending interrupt a CPU should take next. It serves one non-maskable source and a parameterised set of maskable sources, eight by default. It presents the winner as a vector number, a vector address and the accepted priority level. The outputs stay unchanged until the CPU returns a one-cycle acknowledge.

Each maskable source has an enable bit and a 3-bit priority field. Both are loaded through a small register write port. A 2-bit control-mode input selects the masking scheme:

- **Global masking:** the CPU's global mask bit blocks maskable requests. A user mask bit can also block the low-priority half of the sources.
- **Level masking:** a source is accepted only when its priority is above the CPU's 3-bit mask level.

The non-maskable source is edge-triggered and always wins. It is reported as level 8, above every maskable level. An address-mode input chooses the vector-address scaling: ×2 in normal mode and ×4 in advanced mode.

Maskable requests are level inputs, registered once per clock. A hardware-standby input holds the request and grant logic idle, the same way reset does. During standby the configuration registers keep their contents.

Top module: `ic_prio_ctrl`

## Requirements
- R1: Reset state:
  - While `rst` is high, or while `standby` is high, `irq_valid` is 0 and non-maskable edges are discarded.
  - Reset sets every enable bit to 0 and every priority field to 7.
  - Raising `standby` while a grant is shown drops `irq_valid` after the next edge.
- R2: Non-maskable source:
  - A rising edge on `nmi_in` is latched, and this latch is independent of mode, masks and enables.
  - The latched request is granted ahead of every maskable request, with vector number 7 and level 8.
  - Only an acknowledge of that grant clears the latch, and a level held high does not retrigger it.
- R3: Enable bits:
  - A maskable source whose enable bit is 0 never wins, whatever its request.
  - Only enabled sources take part in arbitration.
- R4: Register write port (`wr_en` high for one edge):
  - Address r (0..3) holds the priority of source 2r in bits 6:4 and the priority of source 2r+1 in bits 2:0. Bits 7 and 3 are ignored.
  - Address 4 holds the enable bits, with bit i belonging to source i.
  - Writes to addresses 5..7 change nothing.
- R5: Mode `ctrl_mode`=00:
  - When `gmask`=1, all maskable requests are blocked.
  - Otherwise the enabled requesting source with the lowest index wins.
  - `umask` has no effect in this mode.
- R6: Mode `ctrl_mode`=01:
  - `gmask`=1 blocks all maskable requests.
  - With `gmask`=0 and `umask`=1, sources whose priority field is below 4 are blocked.
  - Among the sources left, the lowest index wins.
- R7: Modes `ctrl_mode`=10 and 11 (level masking):
  - A source is accepted only if its priority is strictly greater than `cpu_lvl`.
  - The highest priority wins, and on equal priority the lower vector number wins.
- R8: Vector numbers and order:
  - Maskable source i issues vector number 84+i. Each group of four sources is one serial channel in the fixed order receive error, receive complete, transmit-data-empty, transmit-end.
  - No vector number other than 7 or 84..91 is ever issued.
- R9: Vector address:
  - With `addr_mode`=0 (normal), `vec_addr` is the vector number ×2, with all upper bits 0.
  - With `addr_mode`=1 (advanced), `vec_addr` is the vector number ×4.
  - The mode is taken in the cycle the grant is captured.
- R10: Hold and acknowledge:
  - While `irq_valid` is 1 and `ack` is 0, `vec_num`, `vec_addr` and `irq_level` hold their values.
  - `ack` with `irq_valid`=1 drops `irq_valid` after the next edge, and no new grant appears in that cycle.
  - `ack` while idle is ignored.
- R11: Latency:
  - A maskable request present at clock edge k is registered at that edge.
  - If it wins, `irq_valid` is 1 after edge k+1 and still 0 after edge k.
  - A non-maskable edge seen at edge k is granted after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Hardware standby; holds requests and grants cleared |
| nmi_in | input | 1 | Non-maskable request, edge-triggered |
| irq_req | input | N_SRC | Maskable request levels, one per source |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| ctrl_mode | input | 2 | Masking scheme select |
| gmask | input | 1 | CPU global mask bit |
| umask | input | 1 | CPU user mask bit |
| cpu_lvl | input | 3 | CPU mask level |
| addr_mode | input | 1 | 0 normal (×2), 1 advanced (×4) vector address |
| ack | input | 1 | CPU acknowledge pulse |
| irq_valid | output | 1 | A grant is being presented |
| vec_num | output | 8 | Granted vector number |
| vec_addr | output | 24 | Granted vector address |
| irq_level | output | 4 | Granted priority level (8 for non-maskable) |

## Verification
The properties assume the following about the inputs:

- `ack` is a single-cycle pulse, issued only in answer to a grant.
- The mode, mask and address-mode inputs may change at any cycle. The properties therefore sample them with `$past` at the edge that captures a grant, and never at later cycles.

The sweeps respect these assumptions. Every case drives mode, masks and requests together at one falling edge and then leaves them unchanged until the grant is sampled. Only the hold test changes inputs while a grant is shown, and there the properties require no change in the outputs.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int PRIO_W  = 3;
    localparam int LVL_W   = 4;
    localparam int VEC_W   = 8;
    localparam int VADDR_W = 24;
    localparam logic [LVL_W-1:0] NMI_LEVEL = 4'd8;

    typedef enum logic [1:0] {
        MODE_GLOBAL      = 2'b00,
        MODE_GLOBAL_USER = 2'b01,
        MODE_LEVEL       = 2'b10,
        MODE_LEVEL_ALT   = 2'b11
    } mask_mode_e;

    typedef struct packed {
        logic               nmi;
        logic [VEC_W-1:0]   vec;
        logic [VADDR_W-1:0] addr;
        logic [LVL_W-1:0]   lvl;
    } grant_t;

    // Normal mode scales by two, advanced mode by four.
    function automatic logic [VADDR_W-1:0] vec_to_addr(
        input logic [VEC_W-1:0] v,
        input logic             adv
    );
        return adv ? {{(VADDR_W-VEC_W-2){1'b0}}, v, 2'b00}
                   : {{(VADDR_W-VEC_W-1){1'b0}}, v, 1'b0};
    endfunction

endpackage

// File: rtl/ic_req_stage.sv
module ic_req_stage #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  logic             nmi_in,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             nmi_clr,
    output logic [N_SRC-1:0] req_q,
    output logic             nmi_pend
);

    logic nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else if (standby) begin
            req_q    <= '0;
            nmi_prev <= nmi_in;
            nmi_pend <= 1'b0;
        end else begin
            req_q    <= irq_req;
            nmi_prev <= nmi_in;
            nmi_pend <= (nmi_pend & ~nmi_clr) | (nmi_in & ~nmi_prev);
        end
    end

endmodule

// File: rtl/ic_cfg_regs.sv
module ic_cfg_regs
    import ic_pkg::*;
#(
    parameter int N_SRC        = 8,
    parameter int NUM_PRI_REGS = 4,
    parameter int AW           = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [7:0]                    wr_data,
    output logic [N_SRC-1:0]              en,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio
);

    logic unused_pad_bits;
    assign unused_pad_bits = wr_data[7] ^ wr_data[3];

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr_en && wr_addr == AW'(NUM_PRI_REGS))
            en <= wr_data[N_SRC-1:0];
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_field
        localparam int REG_IDX = i / 2;
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(REG_IDX));
        if (i % 2 == 0) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)      prio[i] <= 3'd7;
                else if (hit) prio[i] <= wr_data[6:4];
            end
        end else begin : g_lo
            always_ff @(posedge clk) begin
                if (rst)      prio[i] <= 3'd7;
                else if (hit) prio[i] <= wr_data[2:0];
            end
        end
    end

endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
    import ic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0]             req,
    input  logic [N_SRC-1:0]             en,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [1:0]                   mode,
    input  logic                         gmask,
    input  logic                         umask,
    input  logic [PRIO_W-1:0]            cpu_lvl,
    input  logic                         nmi_pend,
    output logic                         hit,
    output logic                         is_nmi,
    output logic [IDX_W-1:0]             idx,
    output logic [LVL_W-1:0]             lvl
);

    logic [N_SRC-1:0] elig;
    logic             level_mode;

    assign level_mode = mask_mode_e'(mode) inside {MODE_LEVEL, MODE_LEVEL_ALT};

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            case (mask_mode_e'(mode))
                MODE_GLOBAL:      elig[i] = !gmask;
                MODE_GLOBAL_USER: elig[i] = !gmask && !(umask && !prio[i][PRIO_W-1]);
                default:          elig[i] = prio[i] > cpu_lvl;
            endcase
            elig[i] = elig[i] && req[i] && en[i];
        end
    end

    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best_key;
        logic [PRIO_W-1:0] key;
        found    = 1'b0;
        best_key = '0;
        idx      = '0;
        // Ascending scan with strict compare: lowest index wins ties.
        for (int i = 0; i < N_SRC; i++) begin
            key = level_mode ? prio[i] : '0;
            if (elig[i] && (!found || key > best_key)) begin
                found    = 1'b1;
                best_key = key;
                idx      = IDX_W'(i);
            end
        end
        is_nmi = nmi_pend;
        hit    = nmi_pend || found;
        lvl    = nmi_pend ? NMI_LEVEL : {1'b0, prio[idx]};
    end

endmodule

// File: rtl/ic_prio_ctrl.sv
module ic_prio_ctrl
    import ic_pkg::*;
#(
    parameter int N_SRC        = 8,
    parameter int MSK_VEC_BASE = 84,
    parameter int NMI_VEC      = 7,
    parameter int NUM_PRI_REGS = (N_SRC + 1) / 2,
    parameter int AW           = $clog2(NUM_PRI_REGS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               standby,
    input  logic               nmi_in,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [1:0]         ctrl_mode,
    input  logic               gmask,
    input  logic               umask,
    input  logic [2:0]         cpu_lvl,
    input  logic               addr_mode,
    input  logic               ack,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   vec_num,
    output logic [VADDR_W-1:0] vec_addr,
    output logic [LVL_W-1:0]   irq_level
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0]             req_q;
    logic                         nmi_pend;
    logic                         nmi_clr;
    logic [N_SRC-1:0]             en;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;
    logic                         arb_hit;
    logic                         arb_nmi;
    logic [IDX_W-1:0]             arb_idx;
    logic [LVL_W-1:0]             arb_lvl;
    logic [VEC_W-1:0]             next_vec;
    logic                         valid_q;
    grant_t                       gnt_q;

    ic_req_stage #(.N_SRC(N_SRC)) u_req (
        .clk      (clk),
        .rst      (rst),
        .standby  (standby),
        .nmi_in   (nmi_in),
        .irq_req  (irq_req),
        .nmi_clr  (nmi_clr),
        .req_q    (req_q),
        .nmi_pend (nmi_pend)
    );

    ic_cfg_regs #(.N_SRC(N_SRC), .NUM_PRI_REGS(NUM_PRI_REGS), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en      (en),
        .prio    (prio)
    );

    ic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .req      (req_q),
        .en       (en),
        .prio     (prio),
        .mode     (ctrl_mode),
        .gmask    (gmask),
        .umask    (umask),
        .cpu_lvl  (cpu_lvl),
        .nmi_pend (nmi_pend),
        .hit      (arb_hit),
        .is_nmi   (arb_nmi),
        .idx      (arb_idx),
        .lvl      (arb_lvl)
    );

    assign next_vec = arb_nmi ? VEC_W'(NMI_VEC)
                              : VEC_W'(MSK_VEC_BASE) + VEC_W'(arb_idx);
    assign nmi_clr  = valid_q && ack && gnt_q.nmi;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            gnt_q   <= '0;
        end else if (standby) begin
            valid_q <= 1'b0;
        end else if (valid_q) begin
            if (ack) valid_q <= 1'b0;
        end else if (arb_hit) begin
            valid_q    <= 1'b1;
            gnt_q.nmi  <= arb_nmi;
            gnt_q.vec  <= next_vec;
            gnt_q.addr <= vec_to_addr(next_vec, addr_mode);
            gnt_q.lvl  <= arb_lvl;
        end
    end

    assign irq_valid = valid_q;
    assign vec_num   = gnt_q.vec;
    assign vec_addr  = gnt_q.addr;
    assign irq_level = gnt_q.lvl;

endmodule

// File: rtl/ic_prio_ctrl_chk.sv
module ic_prio_ctrl_chk
    import ic_pkg::*;
#(
    parameter int N_SRC        = 8,
    parameter int MSK_VEC_BASE = 84,
    parameter int NMI_VEC      = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               standby,
    input logic               ack,
    input logic [1:0]         ctrl_mode,
    input logic               gmask,
    input logic [2:0]         cpu_lvl,
    input logic               addr_mode,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   vec_num,
    input logic [VADDR_W-1:0] vec_addr,
    input logic [LVL_W-1:0]   irq_level
);

    assert_standby_idle_R1: assert property (@(posedge clk) disable iff (rst)
        standby |=> !irq_valid);

    assert_nmi_top_level_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && vec_num == VEC_W'(NMI_VEC)) |-> irq_level == NMI_LEVEL);

    assert_gmask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_valid) && !$past(ctrl_mode[1]) && $past(gmask))
            |-> vec_num == VEC_W'(NMI_VEC));

    assert_level_above_mask_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_valid) && $past(ctrl_mode[1]) && vec_num != VEC_W'(NMI_VEC))
            |-> irq_level > {1'b0, $past(cpu_lvl)});

    assert_no_reserved_vec_R8: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (vec_num == VEC_W'(NMI_VEC)) ||
                      (vec_num >= VEC_W'(MSK_VEC_BASE) &&
                       vec_num <  VEC_W'(MSK_VEC_BASE + N_SRC)));

    assert_addr_scale_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_valid) |-> vec_addr == ($past(addr_mode)
            ? VADDR_W'({vec_num, 2'b00}) : VADDR_W'({vec_num, 1'b0})));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !ack && !standby)
            |=> irq_valid && $stable(vec_num) && $stable(vec_addr) && $stable(irq_level));

    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && ack) |=> !irq_valid);

endmodule

bind ic_prio_ctrl ic_prio_ctrl_chk #(
    .N_SRC(N_SRC), .MSK_VEC_BASE(MSK_VEC_BASE), .NMI_VEC(NMI_VEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .ack       (ack),
    .ctrl_mode (ctrl_mode),
    .gmask     (gmask),
    .cpu_lvl   (cpu_lvl),
    .addr_mode (addr_mode),
    .irq_valid (irq_valid),
    .vec_num   (vec_num),
    .vec_addr  (vec_addr),
    .irq_level (irq_level)
);

// File: tb/tb_ic_prio_ctrl.sv
module tb_ic_prio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int BASE = 84;
    localparam int NMIV = 7;

    logic        clk = 1'b0;
    logic        rst, standby, nmi_in, wr_en, gmask, umask, addr_mode, ack;
    logic [N-1:0] irq_req;
    logic [2:0]  wr_addr, cpu_lvl;
    logic [7:0]  wr_data;
    logic [1:0]  ctrl_mode;
    logic        irq_valid;
    logic [7:0]  vec_num;
    logic [23:0] vec_addr;
    logic [3:0]  irq_level;

    ic_prio_ctrl #(.N_SRC(N), .MSK_VEC_BASE(BASE), .NMI_VEC(NMIV)) dut (
        .clk(clk), .rst(rst), .standby(standby), .nmi_in(nmi_in),
        .irq_req(irq_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_mode(ctrl_mode), .gmask(gmask), .umask(umask), .cpu_lvl(cpu_lvl),
        .addr_mode(addr_mode), .ack(ack), .irq_valid(irq_valid),
        .vec_num(vec_num), .vec_addr(vec_addr), .irq_level(irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int bprio [N];
    logic [7:0] ben;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_cfg();
        for (int r = 0; r < N/2; r++)
            wr(3'(r), {1'b1, 3'(bprio[2*r]), 1'b1, 3'(bprio[2*r+1])});
        wr(3'd4, ben);
    endtask

    function automatic void model(input logic [7:0] rq, input int mode, input bit g,
                                  input bit u, input int lv, output bit found, output int idx);
        int best;
        found = 0; idx = 0; best = -1;
        for (int i = 0; i < N; i++) begin
            bit ok;
            if (mode >= 2)      ok = bprio[i] > lv;
            else if (mode == 1) ok = !g && !(u && bprio[i] < 4);
            else                ok = !g;
            ok = ok && rq[i] && ben[i];
            if (ok && (mode >= 2 ? bprio[i] > best : !found)) begin
                found = 1; idx = i; best = bprio[i];
            end
        end
    endfunction

    task automatic expect_grant(input string tag, input int v, input int l, input bit am);
        check(irq_valid === 1'b1, tag, "irq_valid", irq_valid, 1);
        check(vec_num == 8'(v), tag, "vec_num", vec_num, v);
        check(vec_addr == 24'(am ? v*4 : v*2), tag, "vec_addr", vec_addr, am ? v*4 : v*2);
        check(irq_level == 4'(l), tag, "irq_level", irq_level, l);
    endtask

    task automatic ack_clear(input string tag);
        ack = 1'b1; irq_req = '0;
        @(negedge clk);
        ack = 1'b0;
        check(irq_valid === 1'b0, tag, "valid after ack", irq_valid, 0);
    endtask

    task automatic run_case(input logic [7:0] rq, input int mode, input bit g,
                            input bit u, input int lv, input bit am);
        bit found; int idx; string tag;
        tag = (mode == 0) ? "R5/R3/R4/R8/R9" : (mode == 1) ? "R6/R3/R4/R8/R9" : "R7/R3/R4/R8/R9";
        irq_req = rq; ctrl_mode = 2'(mode); gmask = g; umask = u;
        cpu_lvl = 3'(lv); addr_mode = am;
        repeat (2) @(negedge clk);
        model(rq, mode, g, u, lv, found, idx);
        if (found) begin
            check(irq_valid === 1'b1 && vec_num == 8'(BASE + idx) &&
                  vec_addr == 24'(am ? (BASE+idx)*4 : (BASE+idx)*2) &&
                  irq_level == 4'(bprio[idx]),
                  tag, "grant vec", irq_valid ? vec_num : -1, BASE + idx);
            ack_clear("R10");
        end else begin
            check(irq_valid === 1'b0, tag, "no grant", irq_valid, 0);
            irq_req = '0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; standby = 0; nmi_in = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        gmask = 0; umask = 0; addr_mode = 0; ack = 0; irq_req = '0;
        cpu_lvl = 0; ctrl_mode = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(irq_valid === 1'b0, "R1", "reset valid", irq_valid, 0);

        // R3 / R1: enables reset to 0, so requests are ignored.
        irq_req = 8'hFF;
        repeat (3) @(negedge clk);
        check(irq_valid === 1'b0, "R3", "disabled after reset", irq_valid, 0);
        irq_req = '0;
        @(negedge clk);

        // R4: unmapped writes change nothing; R1: priorities reset to 7.
        wr(3'd7, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
        wr(3'd4, 8'hFF);
        for (int i = 0; i < N; i++) bprio[i] = 7;
        ben = 8'hFF;
        ctrl_mode = 2'b10; cpu_lvl = 3'd6; irq_req = 8'h20;
        repeat (2) @(negedge clk);
        expect_grant("R1_R4", BASE + 5, 7, 0);
        ack_clear("R10");

        // R11 latency.
        ctrl_mode = 2'b00; gmask = 0; irq_req = 8'h08;
        @(negedge clk);
        check(irq_valid === 1'b0, "R11", "after first edge", irq_valid, 0);
        @(negedge clk);
        check(irq_valid === 1'b1, "R11", "after second edge", irq_valid, 1);

        // R10 hold while inputs churn.
        irq_req = 8'hFF; gmask = 1; addr_mode = 1; ctrl_mode = 2'b10;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            expect_grant("R10", BASE + 3, 7, 0);
        end
        ack_clear("R10");
        gmask = 0; addr_mode = 0; ctrl_mode = 2'b00;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check(irq_valid === 1'b0, "R10", "idle ack ignored", irq_valid, 0);

        // R10 back-to-back: gap of one cycle, then next source.
        irq_req = 8'h06;
        repeat (2) @(negedge clk);
        expect_grant("R10", BASE + 1, 7, 0);
        ack = 1'b1; irq_req = 8'h04;
        @(negedge clk);
        ack = 1'b0;
        check(irq_valid === 1'b0, "R10", "gap after ack", irq_valid, 0);
        @(negedge clk);
        expect_grant("R10", BASE + 2, 7, 0);
        ack_clear("R10");

        // R8: each source alone, both address modes.
        for (int i = 0; i < N; i++) begin
            for (int am = 0; am < 2; am++) begin
                irq_req = 8'(1 << i); addr_mode = am[0];
                repeat (2) @(negedge clk);
                expect_grant("R8_R9", BASE + i, 7, am[0]);
                ack_clear("R10");
            end
        end
        addr_mode = 0;

        // R2: NMI beats maskable requests, ignores masks.
        ctrl_mode = 2'b10; cpu_lvl = 3'd0; irq_req = 8'hFF; nmi_in = 1;
        repeat (2) @(negedge clk);
        expect_grant("R2", NMIV, 8, 0);
        ack_clear("R2");
        repeat (3) @(negedge clk);
        check(irq_valid === 1'b0, "R2", "held level no retrigger", irq_valid, 0);
        nmi_in = 0;
        @(negedge clk);
        ctrl_mode = 2'b00; gmask = 1; addr_mode = 1; nmi_in = 1;
        repeat (2) @(negedge clk);
        expect_grant("R2", NMIV, 8, 1);
        ack_clear("R2");
        nmi_in = 0; gmask = 0; addr_mode = 0;
        @(negedge clk);

        // R1: standby discards NMI edges and clears a shown grant.
        standby = 1; nmi_in = 1;
        @(negedge clk);
        nmi_in = 0;
        @(negedge clk);
        standby = 0;
        repeat (3) @(negedge clk);
        check(irq_valid === 1'b0, "R1", "nmi during standby", irq_valid, 0);
        irq_req = 8'h01;
        repeat (2) @(negedge clk);
        check(irq_valid === 1'b1, "R1", "grant before standby", irq_valid, 1);
        standby = 1; irq_req = '0;
        @(negedge clk);
        check(irq_valid === 1'b0, "R1", "standby clears grant", irq_valid, 0);
        standby = 0;
        @(negedge clk);

        // Sweep: four configurations x four modes x all request patterns.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int i = 0; i < N; i++) bprio[i] = (cfg*3 + i*5 + cfg*i) % 8;
            case (cfg)
                0: ben = 8'hFF;
                1: ben = 8'h7E;
                2: ben = 8'hDB;
                default: ben = 8'hF5;
            endcase
            program_cfg();
            for (int mode = 0; mode < 4; mode++) begin
                for (int r = 0; r < 256; r++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    run_case(8'(r), mode, lfsr[0] & lfsr[7], lfsr[1],
                             int'(lfsr[4:2]), lfsr[5]);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule